// File: doc/BRIEF.md
# Genome-Programmed Lookup-Table Fabric with Stuck-At Overlay

The block is a small array of 4-input lookup tables. A single wide configuration word (the genome) sets every table's contents and picks the source of each table input. Repair experiments load genomes into it, and it serves as the substrate on which candidate circuits are tried. The genome goes into a staging register, either one bit per clock or as a whole word. It reaches the fabric only when a commit strobe arrives, so a half-written genome never drives the array.

A second, independent set of registers holds a damage overlay. One mask ties chosen table outputs to a constant, which models an output shorted to a rail. Another mask pins chosen truth-table bits to 0 or 1, which models a stuck cell inside a table. Committing a new genome does not change the overlay, so each candidate is scored on the same damaged fabric.

A parameter selects one of two variants. In the staged variant, tables are grouped into stages of fixed size, outputs are combinational, and an input may only see tables of an earlier stage. In the registered variant, every table output passes through a flip-flop and any table may feed any other, including itself. Primary inputs reach only the entry tables.

Top module: `lutfab_fabric`

## Requirements
- R1: While reset is held and after its release, before any commit, every fabric output is 0 in both variants.
- R2: Gene i sits at genome bits [40*i+39 : 40*i]. Its bits [15:0] are the truth table. The table output equals truth-table bit number {in3,in2,in1,in0}.
- R3: Input k of a table takes its source from the 6-bit selector at gene bits [16+6k+5 : 16+6k]. A value 0..3 selects that primary input, 4..19 selects the output of table (value-4), and 20..63 gives a constant 0.
- R4: A selector naming a primary input on a table with index 4 or above gives a constant 0.
- R5: In the staged variant, table i is in stage i/4. A selector naming a table in the same or a later stage gives a constant 0.
- R6: In the registered variant, outputs change only on a clock edge, to the table values computed from the previous outputs, and any table may feed any other table or itself.
- R7: Writes to the staging register (serial or whole-word) leave the fabric outputs unchanged until the commit strobe. The new genome takes effect at the clock edge that samples the strobe.
- R8: Serial loading shifts in at the top, so after 640 shifts the first bit shifted in is genome bit 0. A whole-word write takes priority over a shift in the same cycle.
- R9: In the registered variant, the commit edge clears every output flip-flop.
- R10: An output fault with enable bit i set forces fabric output i, and the value every consumer of table i sees, to the fault value bit i. This takes effect from the edge that writes the overlay.
- R11: A truth-table fault with enable bit 16*i+b set replaces bit b of table i's truth table with the fault value bit.
- R12: The fault overlay changes only on its write strobe. Reset and genome commits leave it unchanged, apart from reset clearing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_shift_en | input | 1 | Shift one genome bit into staging |
| cfg_sdi | input | 1 | Serial genome bit |
| cfg_par_we | input | 1 | Write the whole staging word |
| cfg_par_data | input | 640 | Whole-word genome |
| cfg_load_done | input | 1 | Commit staged genome to the fabric |
| flt_we | input | 1 | Write the fault overlay |
| flt_out_en | input | 16 | Output-force enables, one per table |
| flt_out_val | input | 16 | Output-force values |
| flt_bit_en | input | 256 | Truth-bit pin enables, 16 per table |
| flt_bit_val | input | 256 | Truth-bit pin values |
| prim_in | input | 4 | Primary inputs |
| fab_out | output | 16 | Output of every table |

## Verification
The hardest states to reach from the ports are those where the routing rules decide the result. These are illegal primary-input picks, same-stage picks in the staged variant, and self-feedback in the registered variant, and they only show when the named source carries a 1. Directed genomes set up these cases so that a missing rule would flip a known output bit. The overlay is set before a later genome commit, which shows that the faults persist. Seeded random genomes with biased selectors, together with sparse random fault masks, then exercise both variants side by side against a bench model over many input sequences.

// File: rtl/lutfab_pkg.sv
package lutfab_pkg;
   // Default geometry shared by the fabric and its users
   localparam int unsigned DEF_N_LUT     = 16;
   localparam int unsigned DEF_K         = 4;
   localparam int unsigned DEF_N_PI      = 4;
   localparam int unsigned DEF_SEL_W     = 6;
   localparam int unsigned DEF_PER_STAGE = 4;

   typedef enum logic [1:0] {SRC_ZERO, SRC_PRIM, SRC_NODE} src_kind_e;

   function automatic src_kind_e classify(input int sel, input int n_pi, input int n_lut);
      if (sel < n_pi) return SRC_PRIM;
      else if (sel < n_pi + n_lut) return SRC_NODE;
      return SRC_ZERO;
   endfunction
endpackage

// File: rtl/lutfab_cfg.sv
module lutfab_cfg #(
   parameter int unsigned GENOME_W = 640
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shift_en,
   input  logic                sdi,
   input  logic                par_we,
   input  logic [GENOME_W-1:0] par_data,
   input  logic                load_done,
   output logic [GENOME_W-1:0] active
);
   logic [GENOME_W-1:0] shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
      end else if (par_we) begin
         shadow <= par_data;
      end else if (shift_en) begin
         shadow <= {sdi, shadow[GENOME_W-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= '0;
      end else if (load_done) begin
         active <= shadow;
      end
   end

   // R7: the live genome moves only on a commit
   a_r7_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
      !load_done |=> $stable(active));
   // R8: a shift without a word write places the serial bit at the top
   a_r8_shift_top: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !par_we) |=> shadow[GENOME_W-1] == $past(sdi));
endmodule

// File: rtl/lutfab_fault.sv
module lutfab_fault #(
   parameter int unsigned N_LUT = 16,
   parameter int unsigned TT_W  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [N_LUT-1:0]      out_en_in,
   input  logic [N_LUT-1:0]      out_val_in,
   input  logic [N_LUT*TT_W-1:0] bit_en_in,
   input  logic [N_LUT*TT_W-1:0] bit_val_in,
   output logic [N_LUT-1:0]      out_en,
   output logic [N_LUT-1:0]      out_val,
   output logic [N_LUT*TT_W-1:0] bit_en,
   output logic [N_LUT*TT_W-1:0] bit_val
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_en  <= '0;
         out_val <= '0;
         bit_en  <= '0;
         bit_val <= '0;
      end else if (we) begin
         out_en  <= out_en_in;
         out_val <= out_val_in;
         bit_en  <= bit_en_in;
         bit_val <= bit_val_in;
      end
   end

   // R12: overlay independent of everything but its own strobe
   a_r12_overlay_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable({out_en, out_val, bit_en, bit_val}));
endmodule

// File: rtl/lutfab_route.sv
module lutfab_route #(
   parameter int unsigned N_LUT  = 16,
   parameter int unsigned K      = 4,
   parameter int unsigned SEL_W  = 6,
   localparam int unsigned TT_W    = 1 << K,
   localparam int unsigned GENE_W  = TT_W + K * SEL_W,
   localparam int unsigned GENOME_W = N_LUT * GENE_W
) (
   input  logic [GENOME_W-1:0]     active,
   input  logic [N_LUT*TT_W-1:0]   bit_en,
   input  logic [N_LUT*TT_W-1:0]   bit_val,
   output logic [N_LUT*TT_W-1:0]   tt_eff,
   output logic [N_LUT*K*SEL_W-1:0] sel_flat
);
   for (genvar i = 0; i < N_LUT; i++) begin : g_gene
      logic [TT_W-1:0] tt_raw;
      logic [TT_W-1:0] pin_en;
      logic [TT_W-1:0] pin_val;
      assign tt_raw  = active[i*GENE_W +: TT_W];
      assign pin_en  = bit_en[i*TT_W +: TT_W];
      assign pin_val = bit_val[i*TT_W +: TT_W];
      assign tt_eff[i*TT_W +: TT_W] = (tt_raw & ~pin_en) | (pin_en & pin_val);
      assign sel_flat[i*K*SEL_W +: K*SEL_W] = active[i*GENE_W + TT_W +: K*SEL_W];
   end
endmodule

// File: rtl/lutfab_fabric.sv
module lutfab_fabric
   import lutfab_pkg::*;
#(
   parameter int unsigned N_LUT     = DEF_N_LUT,
   parameter int unsigned K         = DEF_K,
   parameter int unsigned N_PI      = DEF_N_PI,
   parameter int unsigned N_ENTRY   = 4,
   parameter int unsigned SEL_W     = DEF_SEL_W,
   parameter int unsigned PER_STAGE = DEF_PER_STAGE,
   parameter bit          SEQ_MODE  = 1'b1,
   localparam int unsigned TT_W     = 1 << K,
   localparam int unsigned GENE_W   = TT_W + K * SEL_W,
   localparam int unsigned GENOME_W = N_LUT * GENE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_shift_en,
   input  logic                  cfg_sdi,
   input  logic                  cfg_par_we,
   input  logic [GENOME_W-1:0]   cfg_par_data,
   input  logic                  cfg_load_done,
   input  logic                  flt_we,
   input  logic [N_LUT-1:0]      flt_out_en,
   input  logic [N_LUT-1:0]      flt_out_val,
   input  logic [N_LUT*TT_W-1:0] flt_bit_en,
   input  logic [N_LUT*TT_W-1:0] flt_bit_val,
   input  logic [N_PI-1:0]       prim_in,
   output logic [N_LUT-1:0]      fab_out
);
   if (N_PI + N_LUT > (1 << SEL_W)) begin : g_chk_sel
      $error("selector too narrow for all sources");
   end
   if (N_ENTRY > N_LUT || N_PI > N_LUT) begin : g_chk_entry
      $error("entry tables exceed table count");
   end
   if (PER_STAGE == 0 || K == 0) begin : g_chk_stage
      $error("stage size and table inputs must be nonzero");
   end

   logic [GENOME_W-1:0]      active;
   logic [N_LUT-1:0]         oen, oval;
   logic [N_LUT*TT_W-1:0]    ben, bval;
   logic [N_LUT*TT_W-1:0]    tt_eff;
   logic [N_LUT*K*SEL_W-1:0] sel_flat;
   logic [N_LUT-1:0]         fb;
   logic [N_LUT-1:0]         node_next;

   lutfab_cfg #(.GENOME_W(GENOME_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .shift_en(cfg_shift_en), .sdi(cfg_sdi),
      .par_we(cfg_par_we), .par_data(cfg_par_data), .load_done(cfg_load_done),
      .active(active));

   lutfab_fault #(.N_LUT(N_LUT), .TT_W(TT_W)) u_fault (
      .clk(clk), .rst_n(rst_n), .we(flt_we),
      .out_en_in(flt_out_en), .out_val_in(flt_out_val),
      .bit_en_in(flt_bit_en), .bit_val_in(flt_bit_val),
      .out_en(oen), .out_val(oval), .bit_en(ben), .bit_val(bval));

   lutfab_route #(.N_LUT(N_LUT), .K(K), .SEL_W(SEL_W)) u_route (
      .active(active), .bit_en(ben), .bit_val(bval),
      .tt_eff(tt_eff), .sel_flat(sel_flat));

   // Tables evaluated in index order; staged sources always have lower index
   always_comb begin
      logic [N_LUT-1:0] cur;
      logic [K-1:0]     idx;
      logic             raw;
      int               s;
      cur       = '0;
      node_next = '0;
      for (int i = 0; i < N_LUT; i++) begin
         for (int k = 0; k < K; k++) begin
            s      = int'(sel_flat[(i*K + k)*SEL_W +: SEL_W]);
            idx[k] = 1'b0;
            unique case (classify(s, N_PI, N_LUT))
               SRC_PRIM: if (i < N_ENTRY) idx[k] = prim_in[s];
               SRC_NODE: begin
                  if (SEQ_MODE) idx[k] = fb[s-N_PI];
                  else if ((s - N_PI) / PER_STAGE < i / PER_STAGE) idx[k] = cur[s-N_PI];
               end
               default: idx[k] = 1'b0;
            endcase
         end
         raw    = tt_eff[i*TT_W + int'(idx)];
         cur[i] = oen[i] ? oval[i] : raw;
         node_next[i] = SEQ_MODE ? raw : cur[i];
      end
   end

   if (SEQ_MODE) begin : g_registered
      logic [N_LUT-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             q <= '0;
         else if (cfg_load_done) q <= '0;
         else                    q <= node_next;
      end
      assign fb      = (q & ~oen) | (oen & oval);
      assign fab_out = fb;

      // R9: the commit edge empties the output flip-flops
      a_r9_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_load_done |=> q == '0);
   end else begin : g_staged
      assign fb      = '0;
      assign fab_out = node_next;
   end

   // R10: a forced output shows its fault value at the port
   a_r10_force_visible: assert property (@(posedge clk) disable iff (!rst_n)
      ((fab_out ^ oval) & oen) == '0);
endmodule

// File: tb/lutfab_fabric_tb.sv
module lutfab_fabric_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 16;
   localparam int GW = 40;
   localparam int GN = NL * GW;
   localparam int TB = NL * 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_shift_en = 1'b0, cfg_sdi = 1'b0, cfg_par_we = 1'b0, cfg_load_done = 1'b0;
   logic [GN-1:0] cfg_par_data = '0;
   logic flt_we = 1'b0;
   logic [NL-1:0] flt_out_en = '0, flt_out_val = '0;
   logic [TB-1:0] flt_bit_en = '0, flt_bit_val = '0;
   logic [3:0] prim_in = '0;
   logic [NL-1:0] out_seq, out_comb;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lutfab_fabric #(.SEQ_MODE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_sdi(cfg_sdi),
      .cfg_par_we(cfg_par_we), .cfg_par_data(cfg_par_data), .cfg_load_done(cfg_load_done),
      .flt_we(flt_we), .flt_out_en(flt_out_en), .flt_out_val(flt_out_val),
      .flt_bit_en(flt_bit_en), .flt_bit_val(flt_bit_val), .prim_in(prim_in),
      .fab_out(out_seq));

   lutfab_fabric #(.SEQ_MODE(1'b0)) u_dut_comb (
      .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_sdi(cfg_sdi),
      .cfg_par_we(cfg_par_we), .cfg_par_data(cfg_par_data), .cfg_load_done(cfg_load_done),
      .flt_we(flt_we), .flt_out_en(flt_out_en), .flt_out_val(flt_out_val),
      .flt_bit_en(flt_bit_en), .flt_bit_val(flt_bit_val), .prim_in(prim_in),
      .fab_out(out_comb));

   // ---------------- bench model, built from the requirements ----------------
   logic [GN-1:0] m_shadow = '0, m_active = '0;
   logic [NL-1:0] m_oen = '0, m_oval = '0, m_q = '0;
   logic [TB-1:0] m_ben = '0, m_bval = '0;

   function automatic logic [NL-1:0] model_eval(input bit seq, input logic [NL-1:0] fb);
      logic [NL-1:0] cur, res;
      logic [3:0] idx;
      logic [15:0] tt;
      int s;
      cur = '0;
      res = '0;
      for (int i = 0; i < NL; i++) begin
         for (int k = 0; k < 4; k++) begin
            s = int'(m_active[i*GW + 16 + 6*k +: 6]);
            idx[k] = 1'b0;
            if (s < 4) idx[k] = (i < 4) ? prim_in[s] : 1'b0;
            else if (s < 20) idx[k] = seq ? fb[s-4] : (((s-4)/4 < i/4) ? cur[s-4] : 1'b0);
         end
         tt = (m_active[i*GW +: 16] & ~m_ben[i*16 +: 16]) | (m_ben[i*16 +: 16] & m_bval[i*16 +: 16]);
         res[i] = tt[idx];
         cur[i] = m_oen[i] ? m_oval[i] : tt[idx];
      end
      return seq ? res : cur;
   endfunction

   function automatic logic [NL-1:0] seq_visible();
      return (m_q & ~m_oen) | (m_oen & m_oval);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_shadow <= '0; m_active <= '0; m_q <= '0;
         m_oen <= '0; m_oval <= '0; m_ben <= '0; m_bval <= '0;
      end else begin
         if (cfg_par_we) m_shadow <= cfg_par_data;
         else if (cfg_shift_en) m_shadow <= {cfg_sdi, m_shadow[GN-1:1]};
         if (cfg_load_done) m_active <= m_shadow;
         m_q <= cfg_load_done ? '0 : model_eval(1'b1, seq_visible());
         if (flt_we) begin
            m_oen <= flt_out_en; m_oval <= flt_out_val;
            m_ben <= flt_bit_en; m_bval <= flt_bit_val;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_model(input string req);
      chk({req, " registered"}, out_seq, seq_visible());
      chk({req, " staged"}, out_comb, model_eval(1'b0, '0));
   endtask

   task automatic set_gene(inout logic [GN-1:0] g, input int i, input logic [15:0] tt,
                           input int s0, input int s1, input int s2, input int s3);
      g[i*GW +: 16] = tt;
      g[i*GW + 16 +: 6] = 6'(s0);
      g[i*GW + 22 +: 6] = 6'(s1);
      g[i*GW + 28 +: 6] = 6'(s2);
      g[i*GW + 34 +: 6] = 6'(s3);
   endtask

   task automatic cycle();
      @(negedge clk);
      #1;
   endtask

   task automatic write_word(input logic [GN-1:0] g);
      cfg_par_we = 1'b1; cfg_par_data = g;
      cycle();
      cfg_par_we = 1'b0;
   endtask

   task automatic commit();
      cfg_load_done = 1'b1;
      cycle();
      cfg_load_done = 1'b0;
   endtask

   task automatic write_faults(input logic [NL-1:0] oe, input logic [NL-1:0] ov,
                               input logic [TB-1:0] be, input logic [TB-1:0] bv);
      flt_we = 1'b1; flt_out_en = oe; flt_out_val = ov; flt_bit_en = be; flt_bit_val = bv;
      cycle();
      flt_we = 1'b0;
   endtask

   // ---------------- stimulus ----------------
   logic [GN-1:0] g1, g2;

   initial begin
      void'($urandom(32'd20240611));
      g1 = '0;
      // R2 R3: AND of pi0,pi1; XOR of pi2,pi3; unused inputs pick constant 0 (63)
      set_gene(g1, 0, 16'h8888, 0, 1, 63, 63);
      set_gene(g1, 1, 16'h6666, 2, 3, 63, 63);
      set_gene(g1, 4, 16'hAAAA, 4, 63, 63, 63);   // copies table 0 (earlier stage)
      set_gene(g1, 5, 16'hAAAA, 10, 63, 63, 63);  // copies table 6 (same stage)
      set_gene(g1, 6, 16'hFFFF, 63, 63, 63, 63);  // constant 1
      set_gene(g1, 8, 16'hAAAA, 0, 63, 63, 63);   // primary input on non-entry table
      set_gene(g1, 9, 16'h5555, 63, 63, 63, 63);  // NOT of constant 0
      set_gene(g1, 12, 16'hAAAA, 17, 63, 63, 63); // copies table 13 (same stage)

      repeat (3) cycle();
      chk("R1 reset held registered", out_seq, '0);
      chk("R1 reset held staged", out_comb, '0);
      rst_n = 1'b1;
      prim_in = 4'b0011;
      cycle();
      chk("R1 after release registered", out_seq, '0);
      chk("R1 after release staged", out_comb, '0);

      // R7: staged write must not reach the fabric
      write_word(g1);
      cycle();
      chk("R7 no commit registered", out_seq, '0);
      chk("R7 no commit staged", out_comb, '0);
      commit();
      // staged: tables 0,4,6,9 high; 5,8,12 forced low by routing rules
      chk("R2 R3 R5 staged result", out_comb, 16'h0251);
      chk("R4 primary input on table 8", {15'b0, out_comb[8]}, '0);
      chk("R9 registered right after commit", out_seq, '0);
      cycle();
      chk("R6 first registered step", out_seq, 16'h0241);
      cycle();
      chk("R6 feedback second step", out_seq, 16'h0271);
      for (int n = 0; n < 20; n++) begin
         prim_in = 4'($urandom);
         #1;
         chk_model("R2 R3 R6 random inputs");
         cycle();
      end

      // R10 R11: force table 6 low, table 15 high; pin bit 3 of table 0 low
      prim_in = 4'b0011;
      begin
         logic [TB-1:0] be;
         be = '0; be[3] = 1'b1;
         write_faults(16'h8040, 16'h8000, be, '0);
      end
      chk("R10 R11 staged with overlay", out_comb, 16'h8200);
      chk("R10 forced outputs registered", out_seq & 16'h8040, 16'h8000);
      chk_model("R10 R11 overlay model");

      // R12: commit an empty genome, overlay must stay
      write_word('0);
      commit();
      chk("R12 overlay kept staged", out_comb, 16'h8000);
      chk("R12 overlay kept registered", out_seq, 16'h8000);
      cycle();
      chk("R12 overlay kept next cycle", out_seq, 16'h8000);

      // R8: serial load of g1, bit 0 first, overlay cleared
      write_faults('0, '0, '0, '0);
      for (int n = 0; n < GN; n++) begin
         cfg_shift_en = 1'b1; cfg_sdi = g1[n];
         cycle();
      end
      cfg_shift_en = 1'b0;
      chk("R8 serial not yet live", out_comb, '0);
      commit();
      chk("R8 serial genome staged", out_comb, 16'h0251);
      // R8: word write beats a shift in the same cycle
      cfg_shift_en = 1'b1; cfg_sdi = 1'b1;
      write_word(g1);
      cfg_shift_en = 1'b0;
      commit();
      chk("R8 word write priority", out_comb, 16'h0251);

      // R9: self-toggling table 0 in the registered variant
      g2 = '0;
      set_gene(g2, 0, 16'h5555, 4, 63, 63, 63);
      write_word(g2);
      commit();
      chk("R9 toggle after commit", out_seq, '0);
      chk("R5 self source staged", out_comb, 16'h0001);
      cycle();
      chk("R6 self feedback high", out_seq, 16'h0001);
      cycle();
      chk("R6 self feedback low", out_seq, '0);
      cycle();
      chk("R6 self feedback high again", out_seq, 16'h0001);
      commit();
      chk("R9 commit clears registers", out_seq, '0);

      // random genomes and sparse overlays, both variants against the model
      for (int r = 0; r < 40; r++) begin
         logic [GN-1:0] g;
         logic [TB-1:0] be, bv;
         g = '0;
         for (int i = 0; i < NL; i++)
            set_gene(g, i, 16'($urandom), $urandom % 22, $urandom % 22, $urandom % 22, $urandom % 22);
         for (int w = 0; w < TB/32; w++) begin
            be[w*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
            bv[w*32 +: 32] = $urandom;
         end
         write_faults(16'($urandom & $urandom & $urandom), 16'($urandom), be, bv);
         write_word(g);
         commit();
         for (int n = 0; n < 16; n++) begin
            prim_in = 4'($urandom);
            #1;
            chk_model("R2 R3 R4 R5 R6 R10 R11 random genome");
            cycle();
         end
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule